// File: doc/BRIEF.md
# Horizontal Sync and Back-Porch Regenerator

This block takes a sampled, active-low composite sync stream and turns it into two clean line-rate timing outputs. The first is a horizontal sync of fixed width, one pulse per scan line. The second is an active-low back-porch gate, used to clamp black level during the flat part of the porch. Any clock-domain synchronisation of the incoming sync level is done upstream. The block sees one level sample per clock.

A falling sync edge starts a horizontal pulse only when a hold-off of three quarters of a nominal line has passed since the previous accepted edge. As a result, the extra half-line edges of the equalizing and serration groups produce no output. The time since the last accepted edge is kept in a counter that stops at one and a quarter lines. After a long loss of input, or after reset, the next edge is therefore taken at once and the block locks onto the new phase. The back-porch gate starts on the rising edge that closes an accepted line sync, and never on the rising edges of rejected pulses.

The pulse widths and the discrimination windows all come from one clocks-per-unit parameter, multiplied by unit counts. The whole block therefore scales together to another line rate or clock frequency.

Top module: `hsync_regen`

## Requirements
- R1: A falling edge of `csync_n` that is accepted drives `hsync_n` low on the same clock edge that first samples `csync_n` low.
- R2: Each `hsync_n` low pulse lasts exactly HS_CLKS = HS_UNITS*CLK_PER_UNIT cycles (20 by default), whatever the width of the input sync pulse.
- R3: A falling edge fewer than HOLD_CLKS = 3/4 of LINE_UNITS*CLK_PER_UNIT cycles (192 by default) after the previous accepted edge is ignored and produces no `hsync_n` pulse. Half-line equalizing and serration edges therefore yield one output pulse per line.
- R4: A falling edge HOLD_CLKS or more cycles after the previous accepted edge is accepted, including at a spacing of exactly HOLD_CLKS.
- R5: The time since the last accepted edge saturates at 5/4 of a line. Both after reset and after a gap of any length, the next falling edge is accepted.
- R6: The rising edge of `csync_n` that ends an accepted sync pulse drives `bporch_n` low on the clock edge that first samples `csync_n` high. It stays low for exactly BP_CLKS = BP_UNITS*CLK_PER_UNIT cycles (16 by default).
- R7: A rising edge that ends a rejected sync pulse produces no `bporch_n` pulse.
- R8: While `rst_n` is low, both outputs are high and `csync_n` has no effect. Reset is asynchronous, and the input is taken as high when reset is released.
- R9: The two outputs run independently. When the input sync is shorter than HS_CLKS, `hsync_n` and `bporch_n` are low in the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sampled composite sync level, low during sync |
| hsync_n | output | 1 | Regenerated horizontal sync, active low, registered |
| bporch_n | output | 1 | Back-porch clamp gate, active low, registered |

## Verification
The case where both functions fall in the same cycle is a line sync shorter than the horizontal pulse. Its rising edge fires the back-porch monostable while the horizontal monostable is still running. The bench provokes this with 18-cycle syncs against a 20-cycle horizontal width. It checks that both outputs are low two cycles after the input returns high, and the cycle-by-cycle reference model confirms that each pulse still ends on its own schedule. A second meeting point is a falling edge at exactly the hold-off spacing. There, the ongoing interval count and a fresh acceptance meet in one cycle. The bench places an edge there and another one cycle short of it, and judges them by the pulse count and by the model.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    // Edge events derived from one registered sample of the sync level.
    typedef struct packed {
        logic fall;
        logic rise;
    } sync_edge_t;
endpackage

// File: rtl/hsr_edge.sv
module hsr_edge
    import hsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in_n,
    output sync_edge_t ev
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d   = sync_in_n;
        ev.fall = lvl_q & ~sync_in_n;
        ev.rise = ~lvl_q & sync_in_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/hsr_discrim.sv
module hsr_discrim
    import hsr_pkg::*;
#(
    parameter int HOLD_CLKS = 192,
    parameter int SAT_CLKS  = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  sync_edge_t ev,
    output logic       acc_fall,
    output logic       acc_rise
);
    localparam int CW = $clog2(SAT_CLKS + 1);

    typedef struct packed {
        logic [CW-1:0] since;
        logic          open;
    } disc_t;

    disc_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        acc_fall = ev.fall && (s_q.since >= CW'(HOLD_CLKS));
        acc_rise = ev.rise && s_q.open;
        if (acc_fall)
            s_d.since = CW'(1);
        else if (s_q.since < CW'(SAT_CLKS))
            s_d.since = s_q.since + CW'(1);
        if (acc_fall)
            s_d.open = 1'b1;
        else if (ev.rise)
            s_d.open = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.since <= CW'(SAT_CLKS);
            s_q.open  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/hsr_oneshot.sv
module hsr_oneshot #(
    parameter int WIDTH = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_n
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic          out_n;
    } shot_t;

    shot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig) begin
            s_d.out_n = 1'b0;
            s_d.left  = CW'(WIDTH - 1);
        end else if (s_q.left != '0) begin
            s_d.left  = s_q.left - CW'(1);
        end else begin
            s_d.out_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.left  <= '0;
            s_q.out_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_n = s_q.out_n;
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int CLK_PER_UNIT = 4,
    parameter int LINE_UNITS   = 64,
    parameter int HS_UNITS     = 5,
    parameter int BP_UNITS     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic hsync_n,
    output logic bporch_n
);
    localparam int LINE_CLKS = LINE_UNITS * CLK_PER_UNIT;
    localparam int HOLD_CLKS = (LINE_CLKS * 3) / 4;
    localparam int SAT_CLKS  = (LINE_CLKS * 5) / 4;
    localparam int HS_CLKS   = HS_UNITS * CLK_PER_UNIT;
    localparam int BP_CLKS   = BP_UNITS * CLK_PER_UNIT;

    sync_edge_t ev;
    logic       acc_fall, acc_rise;
    logic [1:0] trig, shot_n;

    hsr_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in_n (csync_n),
        .ev        (ev)
    );

    hsr_discrim #(
        .HOLD_CLKS (HOLD_CLKS),
        .SAT_CLKS  (SAT_CLKS)
    ) u_disc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .acc_fall (acc_fall),
        .acc_rise (acc_rise)
    );

    assign trig = {acc_rise, acc_fall};

    // Index 0: line sync pulse, index 1: back-porch gate.
    for (genvar g = 0; g < 2; g++) begin : g_shot
        localparam int W = (g == 0) ? HS_CLKS : BP_CLKS;
        hsr_oneshot #(.WIDTH(W)) u_shot (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (trig[g]),
            .pulse_n (shot_n[g])
        );
    end

    assign hsync_n  = shot_n[0];
    assign bporch_n = shot_n[1];
endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
    parameter int HS_CLKS   = 20,
    parameter int BP_CLKS   = 16,
    parameter int HOLD_CLKS = 192,
    parameter int SAT_CLKS  = 320
) (
    input logic clk,
    input logic rst_n,
    input logic csync_n,
    input logic hsync_n,
    input logic bporch_n
);
    int hs_run_q, bp_run_q, gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_run_q <= 0;
            bp_run_q <= 0;
            gap_q    <= SAT_CLKS;
        end else begin
            hs_run_q <= hsync_n ? 0 : hs_run_q + 1;
            bp_run_q <= bporch_n ? 0 : bp_run_q + 1;
            if (!hsync_n && $past(hsync_n))
                gap_q <= 1;
            else if (gap_q < SAT_CLKS)
                gap_q <= gap_q + 1;
        end
    end

    // R8
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> hsync_n && bporch_n);

    // R1
    hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> !$past(csync_n));

    // R2
    hs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> hs_run_q == HS_CLKS);

    // R3
    hs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n && $past(hsync_n)) |-> gap_q >= HOLD_CLKS);

    // R6
    bp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bporch_n) |-> $past(csync_n));

    // R6
    bp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bporch_n) |-> bp_run_q == BP_CLKS);
endmodule

bind hsync_regen hsync_regen_chk #(
    .HS_CLKS   (HS_CLKS),
    .BP_CLKS   (BP_CLKS),
    .HOLD_CLKS (HOLD_CLKS),
    .SAT_CLKS  (SAT_CLKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csync_n  (csync_n),
    .hsync_n  (hsync_n),
    .bporch_n (bporch_n)
);

// File: tb/hsync_regen_test.sv
module hsync_regen_test;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT = 4;
    localparam int LINE = 64 * UNIT;
    localparam int HOLD = (LINE * 3) / 4;
    localparam int HSW  = 5 * UNIT;
    localparam int BPW  = 4 * UNIT;
    localparam int HALF = LINE / 2;

    logic clk = 1'b0, rst_n = 1'b0, csync_n = 1'b1;
    logic hsync_n, bporch_n;

    int checks = 0, fails = 0;
    string tag = "R8";
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_regen #(.CLK_PER_UNIT(UNIT), .LINE_UNITS(64), .HS_UNITS(5), .BP_UNITS(4)) uut (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hsync_n(hsync_n), .bporch_n(bporch_n)
    );

    // Behavioural reference: event times in cycle numbers.
    int  cyc = 0;
    bit  m_valid = 0, m_prev = 1, m_open = 0, m_have = 0;
    int  m_last = 0, m_hs = -1000000, m_bp = -1000000;
    bit  exp_hs = 1, exp_bp = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1; m_open = 0; m_have = 0;
            m_hs = -1000000; m_bp = -1000000;
        end else begin
            if (m_prev && !csync_n && (!m_have || cyc - m_last >= HOLD)) begin
                m_have = 1; m_last = cyc; m_hs = cyc; m_open = 1;
            end
            if (!m_prev && csync_n) begin
                if (m_open) m_bp = cyc;
                m_open = 0;
            end
            m_prev = csync_n;
        end
        exp_hs = !(cyc - m_hs < HSW);
        exp_bp = !(cyc - m_bp < BPW);
        cyc++;
        m_valid = 1;
    end

    int hs_falls = 0, bp_falls = 0;
    logic hs_prev = 1, bp_prev = 1;

    always @(negedge clk) begin
        if (m_valid && !done) begin
            checks++;
            if (hsync_n !== exp_hs) begin
                fails++;
                $display("FAIL %s hsync_n=%b expected %b cycle %0d", tag, hsync_n, exp_hs, cyc);
            end
            checks++;
            if (bporch_n !== exp_bp) begin
                fails++;
                $display("FAIL %s bporch_n=%b expected %b cycle %0d", tag, bporch_n, exp_bp, cyc);
            end
            if (hs_prev && !hsync_n) hs_falls++;
            if (bp_prev && !bporch_n) bp_falls++;
            hs_prev = hsync_n;
            bp_prev = bporch_n;
        end
    end

    task automatic check(string r, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", r, act, expv);
        end
    endtask

    task automatic pulse(int low, int period);
        csync_n = 1'b0;
        repeat (low) @(negedge clk);
        csync_n = 1'b1;
        repeat (period - low) @(negedge clk);
    endtask

    task automatic clear_counts();
        hs_falls = 0;
        bp_falls = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R8: input toggles during reset have no effect
        tag = "R8";
        repeat (2) @(negedge clk);
        csync_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hsync_n in reset", hsync_n, 1);
        check("R8 bporch_n in reset", bporch_n, 1);
        csync_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R5: first edge after reset taken; R1 R6 short line syncs
        tag = "R1";
        clear_counts();
        repeat (4) pulse(18, LINE);
        check("R1 line pulses", hs_falls, 4);
        check("R6 back-porch pulses", bp_falls, 4);

        // R9: sync shorter than horizontal width overlaps both outputs
        tag = "R9";
        csync_n = 1'b0;
        repeat (18) @(negedge clk);
        csync_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 hsync_n low with gate", hsync_n, 0);
        check("R9 bporch_n low with sync", bporch_n, 0);
        repeat (LINE - 20) @(negedge clk);

        // R2: long input sync, output width unchanged
        tag = "R2";
        clear_counts();
        repeat (3) pulse(40, LINE);
        check("R2 long-sync pulses", hs_falls, 3);

        // R3 R7: equalizing half-line pulses
        tag = "R3";
        clear_counts();
        repeat (12) pulse(9, HALF);
        check("R3 equalizing hsync count", hs_falls, 6);
        check("R7 equalizing gate count", bp_falls, 6);

        // R3 R7: serration group with wide pulses
        tag = "R7";
        clear_counts();
        repeat (12) pulse(HALF - 18, HALF);
        check("R3 serration hsync count", hs_falls, 6);
        check("R7 serration gate count", bp_falls, 6);
        repeat (HALF) @(negedge clk);

        // R4: exact hold-off spacing accepted, one short rejected
        tag = "R4";
        clear_counts();
        pulse(9, HOLD);
        pulse(9, HOLD - 1);
        pulse(9, LINE);
        pulse(9, LINE);
        check("R4 boundary accept count", hs_falls, 3);
        check("R7 boundary gate count", bp_falls, 3);

        // R5: long gap, counter saturated, next edge accepted
        tag = "R5";
        repeat (3 * LINE) @(negedge clk);
        clear_counts();
        pulse(9, LINE);
        pulse(9, LINE);
        check("R5 reacquire count", hs_falls, 2);

        // R8: reset in the middle of a sync pulse
        tag = "R8";
        csync_n = 1'b0;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check("R8 hsync_n mid reset", hsync_n, 1);
        check("R8 bporch_n mid reset", bporch_n, 1);
        csync_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        tag = "R5";
        clear_counts();
        pulse(9, LINE);
        check("R5 accept after reset", hs_falls, 1);
        check("R6 gate after reset", bp_falls, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule